// File: doc/BRIEF.md
# Two-Thread Instruction Fetch Front End

This block sits at the front of a two-thread in-order core. It holds a fetch program counter for each thread and owns one shared instruction-memory request port. In each cycle at most one thread may use that port. The choice between threads is least-recently-granted. A thread competes only while it has room for the data it would bring back. That room counts what is already buffered plus every fetch still outstanding for it.

Memory answers in request order. Each answer carries the thread number of its request. The 8-byte word is pushed into that thread's private queue of fetch buffer entries, and a downstream aligner drains each queue through its own valid/pop read port. A redirect on a thread loads a new fetch address and empties that thread's queue. Any answers still owed to that thread from before the redirect are then discarded on arrival. The other thread is not affected.

Top module: `fetch_arb2`

## Requirements
- R1: After reset both buffer queues are empty and thread 0 fetches from RST_PC0 while thread 1 fetches from RST_PC1. With both threads eligible, the first request goes to thread 0.
- R2: When both threads are eligible, the request goes to the thread that was not granted most recently, so back-to-back grants alternate 0, 1, 0, 1.
- R3: A grant happens when `req_vld` and `req_rdy` are both high. The request carries the thread's current address on `req_addr` and its number on `req_tid` (0 or 1). After a grant, that thread's next address is 8 higher.
- R4: A thread is eligible only if its buffered entries plus its outstanding fetches, including those to be discarded, are fewer than DEPTH (4). With no eligible thread, `req_vld` is low. A queue never holds more than DEPTH entries.
- R5: When exactly one thread is eligible, it gets the request, whatever the least-recently-granted state says.
- R6: A response with `rsp_tid` = t is appended to thread t's queue. `buf_vld[t]` is high while the queue is non-empty. `buf_data` for that thread shows the oldest entry, and `buf_pop[t]` removes it, so entries leave in arrival order.
- R7: While `redir_vld[t]` is high, thread t makes no request. At the next edge its address becomes the redirect address and its queue is empty.
- R8: Responses to fetches that thread t issued before a redirect are dropped and never appear in its queue. Later responses are stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_vld | input | 2 | Per-thread redirect strobe |
| redir_addr0 | input | ADDR_W | New fetch address for thread 0 |
| redir_addr1 | input | ADDR_W | New fetch address for thread 1 |
| req_vld | output | 1 | Fetch request valid |
| req_rdy | input | 1 | Memory accepts the request |
| req_tid | output | 1 | Thread of the request |
| req_addr | output | ADDR_W | Fetch address |
| rsp_vld | input | 1 | Response valid |
| rsp_tid | input | 1 | Thread tag of the response |
| rsp_data | input | DATA_W | 8-byte fetch word |
| buf_vld | output | 2 | Per-thread queue non-empty |
| buf_pop | input | 2 | Per-thread remove oldest entry |
| buf_data0 | output | DATA_W | Oldest entry of thread 0 |
| buf_data1 | output | DATA_W | Oldest entry of thread 1 |

## Verification
The assertions take two things as given. Memory never returns a response for a thread that has no outstanding fetch. Responses come back in request order. The bench meets both with a model that queues each accepted request and answers from the head of that queue, at most once per cycle and only while answers are enabled. Redirects in the bench use 8-byte aligned addresses. Pops are issued only where the bench expects the queue to be non-empty.

// File: rtl/fetch_arb2.sv
module fetch_arb2 #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RST_PC0 = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] RST_PC1 = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        redir_vld,
  input  logic [ADDR_W-1:0] redir_addr0,
  input  logic [ADDR_W-1:0] redir_addr1,
  output logic              req_vld,
  input  logic              req_rdy,
  output logic              req_tid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_vld,
  input  logic              rsp_tid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        buf_vld,
  input  logic [1:0]        buf_pop,
  output logic [DATA_W-1:0] buf_data0,
  output logic [DATA_W-1:0] buf_data1
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW   = CW + 2;
  localparam int STEP = DATA_W / 8;

  logic [ADDR_W-1:0] pc [2];
  logic [ADDR_W-1:0] rd_addr [2];
  logic [CW-1:0]     cnt [2];
  logic [CW-1:0]     infl [2];
  logic [CW-1:0]     stale [2];
  logic [PW-1:0]     wp [2];
  logic [PW-1:0]     rp [2];
  logic [DATA_W-1:0] mem [2][DEPTH];
  logic              lru;
  logic              sel;
  logic [1:0]        elig, hit, wr, pop, gnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_addr[0] = redir_addr0;
  assign rd_addr[1] = redir_addr1;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      hit[t]  = rsp_vld && (rsp_tid == 1'(t));
      wr[t]   = hit[t] && (stale[t] == '0) && !redir_vld[t];
      pop[t]  = buf_pop[t] && (cnt[t] != '0) && !redir_vld[t];
      elig[t] = !redir_vld[t] &&
                ((SW'(cnt[t]) + SW'(infl[t]) + SW'(stale[t])) < SW'(DEPTH));
    end
  end

  assign sel      = (&elig) ? lru : elig[1];
  assign req_vld  = |elig;
  assign req_tid  = sel;
  assign req_addr = pc[sel];
  assign gnt      = (req_vld && req_rdy) ? (sel ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc[0] <= RST_PC0;
      pc[1] <= RST_PC1;
      lru   <= 1'b0;
      for (int t = 0; t < 2; t++) begin
        cnt[t]   <= '0;
        infl[t]  <= '0;
        stale[t] <= '0;
        wp[t]    <= '0;
        rp[t]    <= '0;
      end
    end else begin
      if (|gnt) lru <= ~sel;
      for (int t = 0; t < 2; t++) begin
        if (redir_vld[t]) begin
          pc[t]    <= rd_addr[t];
          cnt[t]   <= '0;
          infl[t]  <= '0;
          stale[t] <= stale[t] + infl[t] - CW'(hit[t]);
          wp[t]    <= '0;
          rp[t]    <= '0;
        end else begin
          if (gnt[t]) pc[t] <= pc[t] + ADDR_W'(STEP);
          cnt[t]   <= cnt[t] + CW'(wr[t]) - CW'(pop[t]);
          infl[t]  <= infl[t] + CW'(gnt[t]) - CW'(wr[t]);
          stale[t] <= stale[t] - CW'(hit[t] && (stale[t] != '0));
          if (wr[t]) begin
            mem[t][wp[t]] <= rsp_data;
            wp[t]         <= nxt(wp[t]);
          end
          if (pop[t]) rp[t] <= nxt(rp[t]);
        end
      end
    end
  end

  assign buf_vld[0] = cnt[0] != '0;
  assign buf_vld[1] = cnt[1] != '0;
  assign buf_data0  = mem[0][rp[0]];
  assign buf_data1  = mem[1][rp[1]];
endmodule

// File: rtl/fetch_arb2_chk.sv
module fetch_arb2_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    redir_vld,
  input logic          req_vld,
  input logic          req_rdy,
  input logic          req_tid,
  input logic [1:0]    buf_vld,
  input logic [1:0]    elig,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  AST_LRU_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (&elig && req_vld && req_rdy) ##1 (&elig) |-> req_tid != $past(req_tid)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH))); // R4
  AST_LONE_T0: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b01) |-> (req_vld && !req_tid)); // R5
  AST_LONE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b10) |-> (req_vld && req_tid)); // R5
  AST_REDIR_FLUSH0: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld[0] |=> !buf_vld[0]); // R7
  AST_REDIR_FLUSH1: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld[1] |=> !buf_vld[1]); // R7
  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> !redir_vld[req_tid]); // R7
endmodule

bind fetch_arb2 fetch_arb2_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .req_vld(req_vld),
  .req_rdy(req_rdy), .req_tid(req_tid), .buf_vld(buf_vld), .elig(elig),
  .cnt0(cnt[0]), .cnt1(cnt[1])
);

// File: tb/sim_fetch_arb2.sv
module sim_fetch_arb2;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [AW-1:0] A0 = 32'h0000_1000;
  localparam logic [AW-1:0] A1 = 32'h0000_2000;
  localparam logic [AW-1:0] NA = 32'h0000_8800;

  logic clk = 0, rst_n = 0;
  logic [1:0] redir_vld = 0, buf_vld, buf_pop = 0;
  logic [AW-1:0] redir_addr0 = 0, redir_addr1 = 0, req_addr;
  logic req_vld, req_rdy = 0, req_tid, rsp_vld = 0, rsp_tid = 0;
  logic [DW-1:0] rsp_data = 0, buf_data0, buf_data1;
  logic rsp_en = 0;
  logic [AW:0] q[$];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  fetch_arb2 u0 (.*);

  function automatic logic [DW-1:0] dat(input logic t, input logic [AW-1:0] a);
    return {31'h0, t, a};
  endfunction

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step();
    logic [AW:0] e;
    if (req_vld && req_rdy) q.push_back({req_tid, req_addr});
    @(negedge clk);
    if (rsp_en && q.size() > 0) begin
      e = q.pop_front();
      rsp_vld = 1; rsp_tid = e[AW]; rsp_data = dat(e[AW], e[AW-1:0]);
    end else rsp_vld = 0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 buf_vld", 64'(buf_vld), 0);
    chk("R1 req_vld", 64'(req_vld), 1);
    chk("R1 req_tid", 64'(req_tid), 0);
    chk("R1 req_addr", 64'(req_addr), 64'(A0));
  endtask

  task automatic t_fill();
    req_rdy = 1;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R2 tid", 64'(req_tid), 64'(i % 2));
      chk("R3 addr", 64'(req_addr), 64'(((i % 2) ? A1 : A0) + 8 * (i / 2)));
      step();
    end
    #1;
    chk("R4 no request when full", 64'(req_vld), 0);
    req_rdy = 0;
    rsp_en = 1;
    for (int i = 0; i < 9; i++) step();
    rsp_en = 0;
    step();
    chk("R6 both queues filled", 64'(buf_vld), 3);
    chk("R4 still full", 64'(req_vld), 0);
  endtask

  task automatic t_single();
    chk("R6 t1 head", buf_data1, dat(1, A1));
    buf_pop = 2'b10;
    step();
    buf_pop = 0;
    #1;
    chk("R5 lone thread1 vld", 64'(req_vld), 1);
    chk("R5 lone thread1 tid", 64'(req_tid), 1);
  endtask

  task automatic t_drain();
    for (int k = 0; k < 4; k++) begin
      chk("R6 t0 order", buf_data0, dat(0, A0 + 8 * k));
      buf_pop = 2'b01;
      step();
    end
    buf_pop = 0;
    #1;
    chk("R6 t0 empty", 64'(buf_vld[0]), 0);
    chk("R2 lru picks t0", 64'(req_tid), 0);
  endtask

  task automatic t_redirect();
    req_rdy = 1;
    #1;
    chk("R3 t0 addr", 64'(req_addr), 64'(A0 + 32));
    step();
    chk("R3 t1 addr", 64'(req_addr), 64'(A1 + 32));
    chk("R2 t1 tid", 64'(req_tid), 1);
    step();
    req_rdy = 0;
    redir_vld = 2'b10; redir_addr1 = NA;
    #1;
    chk("R7 no t1 request", 64'(req_vld && req_tid), 0);
    step();
    redir_vld = 0;
    #1;
    chk("R7 t1 flushed", 64'(buf_vld[1]), 0);
    rsp_en = 1;
    step(); step(); step();
    rsp_en = 0;
    step();
    chk("R8 stale dropped", 64'(buf_vld), 1);
    chk("R6 t0 new data", buf_data0, dat(0, A0 + 32));
    req_rdy = 1;
    #1;
    chk("R3 t0 next", 64'(req_addr), 64'(A0 + 40));
    step();
    chk("R7 t1 tid", 64'(req_tid), 1);
    chk("R7 t1 new addr", 64'(req_addr), 64'(NA));
    step();
    req_rdy = 0;
    rsp_en = 1;
    step(); step(); step();
    rsp_en = 0;
    step();
    chk("R8 post data kept", 64'(buf_vld[1]), 1);
    chk("R8 post data value", buf_data1, dat(1, NA));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_single();
    t_drain();
    t_redirect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule